// File: doc/BRIEF.md
# Trace Sample Frame Packer

The packer sits between a trace source and a capture memory. While capture is enabled it takes one trace sample on every clock. A sample has three fields: a 3-bit pipeline status, a packet field, and a sync flag. The packed samples leave as 32-bit frames. A configured port width sets how wide the packet field is. It also sets how many samples share one frame: three samples on the 4-bit port, two on the 8-bit port, and one on the 16-bit port.

A sample can carry a trigger request. The packer then writes a reserved trigger code into the slot's status field. The real status moves into the three low bits of the slot's packet field. A one-cycle trigger pulse leaves with the frame that holds the triggered sample.

When capture is switched off with a partial frame pending, that frame is sent on the next cycle. Its unused slots are zero. A formatter-empty output tells the consumer when nothing is left in flight. The port width is taken only while capture is off.

Top module: `trace_frame_packer`

## Requirements
- R1: After reset, `frame_vld` and `frame_trig` are low and `fmt_empty` is high.
- R2: With `port_width` = 2'b00 (4-bit port), each slot is 8 bits: status in [2:0], packet in [6:3] and sync in [7]. Three consecutive samples fill slots at bits 0, 8 and 16, in arrival order. Bits [31:24] are zero.
- R3: With `port_width` = 2'b01 (8-bit port), each slot is 12 bits: status in [2:0], packet in [10:3] and sync in [11]. Two consecutive samples fill slots at bits 0 and 12, in arrival order. Bits [31:24] are zero.
- R4: With `port_width` = 2'b10 or 2'b11 (16-bit port), each sample makes its own frame: status in [2:0], packet in [18:3], sync in [19], and bits [31:20] zero.
- R5: For a sample with `smp_trig` high, the slot's status field holds the trigger code 3'b110. The low three packet bits of the slot hold the sample's real status. The remaining packet bits keep the sample's own packet bits.
- R6: `frame_vld` is high for exactly one cycle. That cycle is the one after the clock edge that accepted the last sample of a frame. No frame is emitted while capture is off and nothing is pending.
- R7: When `cap_en` is low and a partial frame is pending, the partial frame is emitted on the next cycle with its unfilled slots zero.
- R8: `fmt_empty` is low whenever a partial frame is held. It returns high in the same cycle that the frame is emitted.
- R9: `frame_trig` is high exactly in the cycle that emits a frame holding at least one triggered sample. It is never high without `frame_vld`.
- R10: The port width is sampled only at clock edges where `cap_en` is low. A change of `port_width` while capture is on has no effect on the frames until capture has been turned off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_en | input | 1 | Capture enable; one sample is taken per clock while high |
| port_width | input | 2 | Packet width select: 00 = 4 bits, 01 = 8 bits, 1x = 16 bits |
| smp_stat | input | 3 | Pipeline status of the sample |
| smp_pkt | input | PKT_W (16) | Packet field of the sample; the low 4 or 8 bits are used in narrow modes |
| smp_sync | input | 1 | Sync flag of the sample |
| smp_trig | input | 1 | Marks the sample as the trigger cycle |
| frame_vld | output | 1 | Frame strobe, one cycle per frame |
| frame_data | output | FRAME_W (32) | Packed frame, valid while `frame_vld` is high |
| frame_trig | output | 1 | Pulses with the frame holding a triggered sample |
| fmt_empty | output | 1 | High when no partial frame is held |

## Verification
Several properties are checked by assertions on every cycle. The trigger pulse never appears without a frame strobe. The 16-bit mode emits a frame one cycle after each accepted sample. A first narrow-mode sample clears the empty flag. Disabling with a partial frame pending always produces a frame and an empty packer one cycle later. The latched width stays fixed while capture is on. Only the bench's reference model can show that every slot bit lands in the right position for all three widths. It also checks the in-band trigger substitution, the arrival order, the zero fill of a flushed frame, and that a width change made during capture is ignored.

// File: rtl/tfp_pkg.sv
package tfp_pkg;

    localparam logic [1:0] PW_NIB  = 2'b00;
    localparam logic [1:0] PW_BYTE = 2'b01;

    // Bit span of one slot for the selected width (packet plus status and sync).
    function automatic logic [5:0] slot_span(input logic [1:0] w, input int pkt_w);
        int p;
        if (w == PW_NIB)       p = pkt_w / 4;
        else if (w == PW_BYTE) p = pkt_w / 2;
        else                   p = pkt_w;
        return 6'(p + 4);
    endfunction

    // Index of the final slot of a frame for the selected width.
    function automatic logic [1:0] slot_last(input logic [1:0] w);
        if (w == PW_NIB)       return 2'd2;
        else if (w == PW_BYTE) return 2'd1;
        else                   return 2'd0;
    endfunction

endpackage

// File: rtl/tfp_width_cfg.sv
module tfp_width_cfg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_en_i,
    input  logic [1:0] width_req_i,
    output logic [1:0] width_o
);
    logic [1:0] width_d, width_q;

    always_comb begin
        width_d = width_q;
        if (!cap_en_i) width_d = width_req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) width_q <= 2'b00;
        else        width_q <= width_d;
    end

    assign width_o = width_q;

    // R10
    width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en_i |=> $stable(width_o));

endmodule

// File: rtl/tfp_slot_enc.sv
module tfp_slot_enc #(
    parameter int         PKT_W     = 16,
    parameter logic [2:0] TRIG_CODE = 3'b110,
    localparam int        SLOT_MAX  = PKT_W + 4
) (
    input  logic [1:0]          width_i,
    input  logic [2:0]          stat_i,
    input  logic [PKT_W-1:0]    pkt_i,
    input  logic                sync_i,
    input  logic                trig_i,
    output logic [SLOT_MAX-1:0] slot_o
);
    logic [2:0]          stat_f;
    logic [PKT_W-1:0]    pkt_f;
    logic [SLOT_MAX-1:0] cand [3];
    logic [1:0]          sel;

    always_comb begin
        stat_f = stat_i;
        pkt_f  = pkt_i;
        if (trig_i) begin
            stat_f     = TRIG_CODE;
            pkt_f[2:0] = stat_i;
        end
    end

    for (genvar g = 0; g < 3; g++) begin : g_var
        localparam int PW = PKT_W >> (2 - g);
        assign cand[g] = SLOT_MAX'({sync_i, pkt_f[PW-1:0], stat_f});
    end

    assign sel    = width_i[1] ? 2'd2 : (width_i[0] ? 2'd1 : 2'd0);
    assign slot_o = cand[sel];

endmodule

// File: rtl/tfp_frame_acc.sv
module tfp_frame_acc
    import tfp_pkg::*;
#(
    parameter int  PKT_W    = 16,
    parameter int  FRAME_W  = 32,
    localparam int SLOT_MAX = PKT_W + 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_en_i,
    input  logic [1:0]          width_i,
    input  logic [SLOT_MAX-1:0] slot_i,
    input  logic                trig_i,
    output logic                frame_vld_o,
    output logic [FRAME_W-1:0]  frame_data_o,
    output logic                frame_trig_o,
    output logic                fmt_empty_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] acc;
        logic [1:0]         fill;
        logic               trig;
        logic               vld;
        logic [FRAME_W-1:0] data;
        logic               trg;
    } acc_st_t;

    acc_st_t st_d, st_q;

    logic [7:0]         shamt;
    logic [FRAME_W-1:0] merged;
    logic               trig_m;

    always_comb begin
        shamt  = 8'(st_q.fill) * 8'(slot_span(width_i, PKT_W));
        merged = st_q.acc | (FRAME_W'(slot_i) << shamt);
        trig_m = st_q.trig | trig_i;

        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.trg = 1'b0;

        if (cap_en_i) begin
            if (st_q.fill == slot_last(width_i)) begin
                st_d.vld  = 1'b1;
                st_d.data = merged;
                st_d.trg  = trig_m;
                st_d.acc  = '0;
                st_d.fill = 2'd0;
                st_d.trig = 1'b0;
            end else begin
                st_d.acc  = merged;
                st_d.fill = st_q.fill + 2'd1;
                st_d.trig = trig_m;
            end
        end else if (st_q.fill != 2'd0) begin
            st_d.vld  = 1'b1;
            st_d.data = st_q.acc;
            st_d.trg  = st_q.trig;
            st_d.acc  = '0;
            st_d.fill = 2'd0;
            st_d.trig = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_vld_o  = st_q.vld;
    assign frame_data_o = st_q.data;
    assign frame_trig_o = st_q.trg;
    assign fmt_empty_o  = (st_q.fill == 2'd0);

    // R9
    trig_with_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_trig_o |-> frame_vld_o);

    // R4
    wide_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en_i && width_i[1]) |=> (frame_vld_o && fmt_empty_o));

    // R8
    narrow_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en_i && !width_i[1] && fmt_empty_o) |=> !fmt_empty_o);

    // R7
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en_i && !fmt_empty_o) |=> (frame_vld_o && fmt_empty_o));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en_i && fmt_empty_o) |=> !frame_vld_o);

endmodule

// File: rtl/trace_frame_packer.sv
module trace_frame_packer #(
    parameter int         PKT_W     = 16,
    parameter int         FRAME_W   = 32,
    parameter logic [2:0] TRIG_CODE = 3'b110
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_en,
    input  logic [1:0]         port_width,
    input  logic [2:0]         smp_stat,
    input  logic [PKT_W-1:0]   smp_pkt,
    input  logic               smp_sync,
    input  logic               smp_trig,
    output logic               frame_vld,
    output logic [FRAME_W-1:0] frame_data,
    output logic               frame_trig,
    output logic               fmt_empty
);
    localparam int SLOT_MAX = PKT_W + 4;

    logic [1:0]          width_w;
    logic [SLOT_MAX-1:0] slot_w;

    tfp_width_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_en_i    (cap_en),
        .width_req_i (port_width),
        .width_o     (width_w)
    );

    tfp_slot_enc #(.PKT_W(PKT_W), .TRIG_CODE(TRIG_CODE)) u_enc (
        .width_i (width_w),
        .stat_i  (smp_stat),
        .pkt_i   (smp_pkt),
        .sync_i  (smp_sync),
        .trig_i  (smp_trig),
        .slot_o  (slot_w)
    );

    tfp_frame_acc #(.PKT_W(PKT_W), .FRAME_W(FRAME_W)) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_en_i     (cap_en),
        .width_i      (width_w),
        .slot_i       (slot_w),
        .trig_i       (smp_trig),
        .frame_vld_o  (frame_vld),
        .frame_data_o (frame_data),
        .frame_trig_o (frame_trig),
        .fmt_empty_o  (fmt_empty)
    );

endmodule

// File: tb/trace_frame_packer_tb_top.sv
`timescale 1ns/1ps
module trace_frame_packer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_en = 1'b0;
    logic [1:0]  port_width = 2'b00;
    logic [2:0]  smp_stat = '0;
    logic [15:0] smp_pkt = '0;
    logic        smp_sync = 1'b0;
    logic        smp_trig = 1'b0;
    logic        frame_vld;
    logic [31:0] frame_data;
    logic        frame_trig;
    logic        fmt_empty;

    always #2 clk = ~clk;

    trace_frame_packer dut_i (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .port_width(port_width),
        .smp_stat(smp_stat), .smp_pkt(smp_pkt), .smp_sync(smp_sync),
        .smp_trig(smp_trig), .frame_vld(frame_vld), .frame_data(frame_data),
        .frame_trig(frame_trig), .fmt_empty(fmt_empty)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // behavioural model state
    int     w_m = 0;
    longint q_m[$];
    bit     trig_m = 0;
    bit     exp_vld = 0, exp_trig = 0, exp_empty = 1;
    longint exp_data = 0;

    function automatic int pbits(int w);
        return (w == 0) ? 4 : ((w == 1) ? 8 : 16);
    endfunction

    function automatic longint mk_slot(int w, int st, int pk, int sy, int tg);
        int p = pbits(w);
        longint pkm = longint'(pk) & ((64'd1 << p) - 1);
        longint s = st;
        if (tg != 0) begin
            pkm = (pkm & ~64'd7) | st;
            s = 6;   // trigger code 3'b110 (R5)
        end
        return s | (pkm << 3) | (longint'(sy) << (p + 3));
    endfunction

    function automatic void emit();
        longint d = 0;
        int span = pbits(w_m) + 4;
        foreach (q_m[i]) d = d | (q_m[i] << (i * span));
        exp_vld = 1; exp_data = d; exp_trig = trig_m;
        q_m.delete(); trig_m = 0;
    endfunction

    function automatic void model_step(bit en, int pw, int st, int pk, int sy, int tg);
        int per;
        exp_vld = 0; exp_trig = 0;
        if (en) begin
            per = (w_m == 0) ? 3 : ((w_m == 1) ? 2 : 1);
            q_m.push_back(mk_slot(w_m, st, pk, sy, tg));
            trig_m = trig_m | (tg != 0);
            if (q_m.size() == per) emit();
        end else begin
            if (q_m.size() > 0) emit();
            w_m = (pw == 3) ? 2 : pw;
        end
        exp_empty = (q_m.size() == 0);
    endfunction

    task automatic check_outputs();
        n_cmp++;
        if (frame_vld !== exp_vld) begin
            n_bad++;
            $display("FAIL %s frame_vld act=%0b exp=%0b", cur_req, frame_vld, exp_vld);
        end
        n_cmp++;
        if (fmt_empty !== exp_empty) begin
            n_bad++;
            $display("FAIL %s fmt_empty act=%0b exp=%0b", cur_req, fmt_empty, exp_empty);
        end
        n_cmp++;
        if (frame_trig !== exp_trig) begin
            n_bad++;
            $display("FAIL %s frame_trig act=%0b exp=%0b", cur_req, frame_trig, exp_trig);
        end
        if (exp_vld) begin
            n_cmp++;
            if (frame_data !== 32'(exp_data)) begin
                n_bad++;
                $display("FAIL %s frame_data act=%08h exp=%08h", cur_req, frame_data, 32'(exp_data));
            end
        end
    endtask

    task automatic cyc(bit en, int pw, int st, int pk, int sy, int tg);
        @(negedge clk);
        check_outputs();
        cap_en = en; port_width = 2'(pw); smp_stat = 3'(st);
        smp_pkt = 16'(pk); smp_sync = sy[0]; smp_trig = tg[0];
        model_step(en, pw, st, pk, sy, tg);
    endtask

    task automatic rnd_samples(int n, int pw, int trig_pct);
        for (int i = 0; i < n; i++)
            cyc(1, pw, $urandom_range(7), $urandom_range(65535), $urandom_range(1),
                ($urandom_range(99) < trig_pct) ? 1 : 0);
    endtask

    task automatic idle(int n, int pw);
        for (int i = 0; i < n; i++) cyc(0, pw, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state compared on first cycles
        cur_req = "R1";
        idle(2, 0);

        // R2 nibble port, directed pattern then random
        cur_req = "R2";
        cyc(1, 0, 5, 16'h000A, 1, 0);
        cyc(1, 0, 1, 16'h0003, 0, 0);
        cyc(1, 0, 7, 16'h000F, 1, 0);
        rnd_samples(9, 0, 0);
        idle(1, 1);

        // R3 byte port
        cur_req = "R3";
        cyc(1, 1, 2, 16'h00C3, 1, 0);
        cyc(1, 1, 4, 16'h005A, 0, 0);
        rnd_samples(8, 1, 0);
        idle(1, 2);

        // R4 wide port, both codes
        cur_req = "R4";
        rnd_samples(6, 2, 0);
        idle(1, 3);
        rnd_samples(6, 3, 0);
        idle(1, 0);

        // R5 / R9 triggers in each width
        cur_req = "R5";
        cyc(1, 0, 3, 16'h000D, 0, 0);
        cyc(1, 0, 4, 16'h000F, 1, 1);
        cyc(1, 0, 0, 16'h0000, 0, 0);
        cur_req = "R9";
        rnd_samples(12, 0, 30);
        idle(1, 1);
        cur_req = "R5";
        rnd_samples(10, 1, 30);
        idle(1, 2);
        cur_req = "R9";
        rnd_samples(10, 2, 30);
        idle(1, 0);

        // R7 / R8 partial flush
        cur_req = "R7";
        rnd_samples(2, 0, 0);
        idle(3, 0);
        cur_req = "R8";
        cyc(1, 0, 6, 16'h0009, 1, 1);
        idle(2, 1);
        rnd_samples(1, 1, 0);
        idle(2, 1);

        // R6 idle no frames
        cur_req = "R6";
        idle(5, 0);

        // R10 width change during capture ignored
        cur_req = "R10";
        rnd_samples(2, 0, 0);
        rnd_samples(7, 2, 0);
        rnd_samples(4, 1, 0);
        idle(1, 2);
        rnd_samples(3, 0, 0);
        idle(1, 0);

        // mixed random traffic
        cur_req = "R2";
        for (int k = 0; k < 60; k++) begin
            int pw = $urandom_range(3);
            rnd_samples($urandom_range(1, 7), pw, 20);
            idle($urandom_range(1, 3), $urandom_range(3));
        end
        idle(3, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule